// File: doc/BRIEF.md
# In-Order Retirement Buffer with Operand Forwarding

This block lets the functional units of a pipelined core finish work in any order, while the architectural register file still sees its writes in program order. Every instruction that issues takes the slot at the tail of a circular buffer, and the slot index goes back to the issue logic as a tag. A functional unit that finishes returns its result together with that tag and an exception code. The slot at the head retires one instruction per cycle, and only once it has finished cleanly.

When the head slot holds an exception, retirement freezes and issue stops. The block then presents the program counter that was captured at issue, so that a precise trap can be taken. A flush input empties the buffer after the handler has run. Store instructions take a slot without a register destination. When such a slot retires, the block pulses a release for one held memory write.

Two source-operand lookups compare a register number against the slots that are still pending. Only the youngest slot that writes a given register takes part in this compare. A match on a finished slot supplies its result in place of the register-file value. A match on an unfinished slot reports the operand as not ready.

Top module: `rob_core`

## Requirements
- R1: After reset, the buffer is empty: `iss_stall`=0, `wb_en`=0, `st_release`=0, `trap_valid`=0, and both lookups report no hit.
- R2: An accepted issue returns on `iss_tag` the current tail index. Tags run 0,1,…,DEPTH-1 and then wrap to 0.
- R3: When DEPTH slots are occupied, `iss_stall` is 1 and an `iss_valid` is not accepted: no slot is taken and no later retirement comes from it.
- R4: A completion (`cpl_valid` with `cpl_tag`) that is not for the head slot causes no register write. Writes happen only in issue order.
- R5: The cycle after the head slot has a clean completion (`cpl_exc`=0), `wb_en`=1 with that slot's destination on `wb_reg` and its result on `wb_data`. At most one slot retires per cycle.
- R6: When the head slot has finished with a nonzero exception code, `trap_valid`=1, `trap_pc` shows its issue PC and `trap_code` shows its code. `iss_stall`=1, and `wb_en` stays 0 even though younger slots have finished. All of this holds until flush.
- R7: A lookup that matches a finished pending slot gives hit=1, ready=1, and the value is that slot's result.
- R8: A lookup that matches an unfinished pending slot gives hit=1 and ready=0.
- R9: When two pending slots write the same register, only the younger one matches a lookup. Its state alone sets ready and the value.
- R10: A store slot (`iss_store`=1) never matches a lookup. When it retires cleanly, it raises `st_release` for one cycle with `wb_en`=0.
- R11: `flush`=1 empties the buffer: the trap clears, lookups miss, and the next issue gets tag 0.
- R12: A lookup with no match gives hit=0 and ready=1, and passes the register-file input value through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the buffer and reset the pointers |
| iss_valid | input | 1 | Issue request |
| iss_dst | input | REG_AW | Destination register of the issuing instruction |
| iss_store | input | 1 | Issuing instruction is a store (no register destination) |
| iss_pc | input | PC_W | Program counter of the issuing instruction |
| iss_stall | output | 1 | Issue not accepted (buffer full or trap pending) |
| iss_tag | output | TAG_W | Slot index given to the issuing instruction |
| cpl_valid | input | 1 | Completion from a functional unit |
| cpl_tag | input | TAG_W | Slot index of the completing instruction |
| cpl_data | input | DATA_W | Result |
| cpl_exc | input | EXC_W | Exception code, 0 = none |
| wb_en | output | 1 | Register-file write enable |
| wb_reg | output | REG_AW | Register-file write address |
| wb_data | output | DATA_W | Register-file write data |
| opa_reg | input | REG_AW | Source A register number |
| opa_rf | input | DATA_W | Source A value from the register file |
| opa_hit | output | 1 | Source A matches a pending slot |
| opa_ready | output | 1 | Source A value is usable |
| opa_val | output | DATA_W | Source A operand value |
| opb_reg | input | REG_AW | Source B register number |
| opb_rf | input | DATA_W | Source B value from the register file |
| opb_hit | output | 1 | Source B matches a pending slot |
| opb_ready | output | 1 | Source B value is usable |
| opb_val | output | DATA_W | Source B operand value |
| trap_valid | output | 1 | Head slot holds an exception |
| trap_pc | output | PC_W | Precise PC of the faulting instruction |
| trap_code | output | EXC_W | Exception code of the faulting instruction |
| st_release | output | 1 | Release one held store to memory |

## Verification
The main pattern issues six instructions and completes them in reverse order. This shows that a finished younger slot is held back until the head finishes, and that the retirements then drain in issue order, one per cycle. A second pattern fills all eight slots with tags that wrap, offers one extra issue and completes in order. It separates a correct full stall from an extra slot being taken. Directed cases repeat a destination to tell youngest-only matching apart from matching any slot. They also put a store through retirement, and place a fault behind a finished younger slot to show that the trap blocks writes until flush.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    HS_EMPTY  = 2'd0,
    HS_WAIT   = 2'd1,
    HS_RETIRE = 2'd2,
    HS_TRAP   = 2'd3
  } head_state_e;

  // Classify the head slot from its occupancy, finish and fault state.
  function automatic head_state_e classify_head(input logic busy,
                                                input logic done,
                                                input logic fault);
    if (!busy)      return HS_EMPTY;
    else if (!done) return HS_WAIT;
    else if (fault) return HS_TRAP;
    else            return HS_RETIRE;
  endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc,
  input  logic             retire,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  function automatic logic [TAG_W-1:0] ptr_next(input logic [TAG_W-1:0] p);
    if (p == TAG_W'(DEPTH - 1)) return '0;
    else                        return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc)  tail <= ptr_next(tail);
      if (retire) head <= ptr_next(head);
      case ({alloc, retire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full = (count == CNT_W'(DEPTH));

  // R3
  count_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !retire && !flush) |=> (count == $past(count) + 1'b1));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc);

endmodule

// File: rtl/rob_bypass.sv
module rob_bypass #(
  parameter int DEPTH  = 8,
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              slot_busy,
  input  logic [DEPTH-1:0]              slot_fwd,
  input  logic [DEPTH-1:0]              slot_done,
  input  logic [DEPTH-1:0][REG_AW-1:0]  slot_dst,
  input  logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
  input  logic [REG_AW-1:0]             src_reg,
  input  logic [DATA_W-1:0]             src_rf,
  output logic                          src_hit,
  output logic                          src_ready,
  output logic [DATA_W-1:0]             src_val
);

  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = slot_busy[i] & slot_fwd[i] & (slot_dst[i] == src_reg);
  end

  logic [DATA_W-1:0] sel_data;
  logic              sel_done;

  always_comb begin
    sel_data = '0;
    sel_done = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        sel_data = sel_data | slot_data[i];
        sel_done = sel_done | slot_done[i];
      end
    end
  end

  assign src_hit   = |match;
  assign src_ready = !src_hit || sel_done;
  assign src_val   = src_hit ? sel_data : src_rf;

  // R9
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH  = 8,
  parameter int REG_AW = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int EXC_W  = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              iss_valid,
  input  logic [REG_AW-1:0] iss_dst,
  input  logic              iss_store,
  input  logic [PC_W-1:0]   iss_pc,
  output logic              iss_stall,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [DATA_W-1:0] cpl_data,
  input  logic [EXC_W-1:0]  cpl_exc,
  output logic              wb_en,
  output logic [REG_AW-1:0] wb_reg,
  output logic [DATA_W-1:0] wb_data,
  input  logic [REG_AW-1:0] opa_reg,
  input  logic [DATA_W-1:0] opa_rf,
  output logic              opa_hit,
  output logic              opa_ready,
  output logic [DATA_W-1:0] opa_val,
  input  logic [REG_AW-1:0] opb_reg,
  input  logic [DATA_W-1:0] opb_rf,
  output logic              opb_hit,
  output logic              opb_ready,
  output logic [DATA_W-1:0] opb_val,
  output logic              trap_valid,
  output logic [PC_W-1:0]   trap_pc,
  output logic [EXC_W-1:0]  trap_code,
  output logic              st_release
);
  import rob_pkg::*;

  logic [DEPTH-1:0]             slot_busy, slot_done, slot_fwd, slot_st;
  logic [DEPTH-1:0][REG_AW-1:0] slot_dst;
  logic [DEPTH-1:0][DATA_W-1:0] slot_data;
  logic [DEPTH-1:0][EXC_W-1:0]  slot_exc;
  logic [DEPTH-1:0][PC_W-1:0]   slot_pc;

  logic [TAG_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             full;
  logic             alloc, retire;
  head_state_e      hstate;

  // Named internal events
  assign hstate    = classify_head(slot_busy[head], slot_done[head], |slot_exc[head]);
  assign trap_valid = (hstate == HS_TRAP);
  assign iss_stall = full | trap_valid;
  assign alloc     = iss_valid & ~iss_stall & ~flush;
  assign retire    = (hstate == HS_RETIRE) & ~flush;
  assign iss_tag   = tail;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .alloc  (alloc),
    .retire (retire),
    .head   (head),
    .tail   (tail),
    .count  (count),
    .full   (full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic is_tail, is_head, hit_cpl, older_same;
    assign is_tail    = (tail == TAG_W'(i));
    assign is_head    = (head == TAG_W'(i));
    assign hit_cpl    = cpl_valid && (cpl_tag == TAG_W'(i)) && slot_busy[i];
    assign older_same = slot_busy[i] && (slot_dst[i] == iss_dst) && !iss_store;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_busy[i] <= 1'b0;
        slot_done[i] <= 1'b0;
        slot_fwd[i]  <= 1'b0;
        slot_st[i]   <= 1'b0;
        slot_dst[i]  <= '0;
        slot_data[i] <= '0;
        slot_exc[i]  <= '0;
        slot_pc[i]   <= '0;
      end else if (flush) begin
        slot_busy[i] <= 1'b0;
        slot_done[i] <= 1'b0;
        slot_fwd[i]  <= 1'b0;
        slot_exc[i]  <= '0;
      end else begin
        if (alloc && is_tail) begin
          slot_busy[i] <= 1'b1;
          slot_done[i] <= 1'b0;
          slot_fwd[i]  <= !iss_store;
          slot_st[i]   <= iss_store;
          slot_dst[i]  <= iss_dst;
          slot_pc[i]   <= iss_pc;
          slot_exc[i]  <= '0;
        end else begin
          if (alloc && older_same) slot_fwd[i] <= 1'b0;
          if (retire && is_head) begin
            slot_busy[i] <= 1'b0;
            slot_done[i] <= 1'b0;
            slot_fwd[i]  <= 1'b0;
          end else if (hit_cpl) begin
            slot_done[i] <= 1'b1;
            slot_data[i] <= cpl_data;
            slot_exc[i]  <= cpl_exc;
          end
        end
      end
    end
  end

  assign wb_en      = retire & ~slot_st[head];
  assign st_release = retire &  slot_st[head];
  assign wb_reg     = slot_dst[head];
  assign wb_data    = slot_data[head];
  assign trap_pc    = slot_pc[head];
  assign trap_code  = slot_exc[head];

  rob_bypass #(.DEPTH(DEPTH), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_byp_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_busy (slot_busy),
    .slot_fwd  (slot_fwd),
    .slot_done (slot_done),
    .slot_dst  (slot_dst),
    .slot_data (slot_data),
    .src_reg   (opa_reg),
    .src_rf    (opa_rf),
    .src_hit   (opa_hit),
    .src_ready (opa_ready),
    .src_val   (opa_val)
  );

  rob_bypass #(.DEPTH(DEPTH), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_byp_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_busy (slot_busy),
    .slot_fwd  (slot_fwd),
    .slot_done (slot_done),
    .slot_dst  (slot_dst),
    .slot_data (slot_data),
    .src_reg   (opb_reg),
    .src_rf    (opb_rf),
    .src_hit   (opb_hit),
    .src_ready (opb_ready),
    .src_val   (opb_val)
  );

  // R6
  no_write_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !wb_en);

  // R6
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !flush) |=> (trap_valid && $stable(trap_pc)));

  // R10
  store_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_en && st_release));

  // R5
  head_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !flush) |=> (count == $past(count) - 1'b1) || $past(alloc));

endmodule

// File: tb/rob_core_tb.sv
module rob_core_tb;
  localparam int DEPTH = 8;

  logic        clk = 0, rst_n = 0, flush = 0;
  logic        iss_valid = 0, iss_store = 0;
  logic [4:0]  iss_dst = 0;
  logic [31:0] iss_pc = 0;
  logic        iss_stall;
  logic [2:0]  iss_tag;
  logic        cpl_valid = 0;
  logic [2:0]  cpl_tag = 0;
  logic [31:0] cpl_data = 0;
  logic [3:0]  cpl_exc = 0;
  logic        wb_en;
  logic [4:0]  wb_reg;
  logic [31:0] wb_data;
  logic [4:0]  opa_reg = 0, opb_reg = 0;
  logic [31:0] opa_rf = 0, opb_rf = 0;
  logic        opa_hit, opa_ready, opb_hit, opb_ready;
  logic [31:0] opa_val, opb_val;
  logic        trap_valid, st_release;
  logic [31:0] trap_pc;
  logic [3:0]  trap_code;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  rob_core u_dut (.*);

  // Rows: {dest[4:0], data[31:0]}
  localparam logic [36:0] TBL [0:5] = '{
    {5'd1,  32'h0000_1111}, {5'd2,  32'h0000_2222}, {5'd3,  32'h0000_3333},
    {5'd4,  32'h0000_4444}, {5'd5,  32'h0000_5555}, {5'd6,  32'h0000_6666}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_issue(input logic [4:0] d, input logic [31:0] pc,
                          input logic st, output logic [2:0] tag);
    iss_valid = 1; iss_dst = d; iss_pc = pc; iss_store = st;
    #1 tag = iss_tag;
    @(negedge clk);
    iss_valid = 0; iss_store = 0;
  endtask

  task automatic do_cpl(input logic [2:0] t, input logic [31:0] d, input logic [3:0] e);
    cpl_valid = 1; cpl_tag = t; cpl_data = d; cpl_exc = e;
    @(negedge clk);
    cpl_valid = 0; cpl_exc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] tg;
    int commits;
    logic saw31;

    @(negedge clk); @(negedge clk);
    rst_n = 1;
    opa_reg = 5'd9; opa_rf = 32'hABCD;
    #1;
    // R1 reset state
    chk("R1 stall", iss_stall, 0);
    chk("R1 wb_en", wb_en, 0);
    chk("R1 trap", trap_valid, 0);
    chk("R1 release", st_release, 0);
    chk("R1 hit", opa_hit, 0);
    @(negedge clk);

    // Table walk: issue in order, complete in reverse
    for (int i = 0; i < 6; i++) begin
      do_issue(TBL[i][36:32], 32'h100 + i*4, 0, tg);
      chk("R2 tag", tg, i);
    end
    opa_reg = TBL[2][36:32]; #1;
    chk("R8 pending hit", opa_hit, 1);
    chk("R8 pending ready", opa_ready, 0);
    for (int i = 5; i >= 1; i--) begin
      do_cpl(i[2:0], TBL[i][31:0], 0);
      #1 chk("R4 no early write", wb_en, 0);
    end
    opa_reg = TBL[3][36:32]; #1;
    chk("R7 hit", opa_hit, 1);
    chk("R7 ready", opa_ready, 1);
    chk("R7 value", opa_val, TBL[3][31:0]);
    opb_reg = 5'd31; opb_rf = 32'hDEAD; #1;
    chk("R12 hit", opb_hit, 0);
    chk("R12 ready", opb_ready, 1);
    chk("R12 value", opb_val, 32'hDEAD);
    do_cpl(3'd0, TBL[0][31:0], 0);
    for (int k = 0; k < 6; k++) begin
      #1;
      chk("R5 wb_en", wb_en, 1);
      chk("R5 wb_reg", wb_reg, TBL[k][36:32]);
      chk("R5 wb_data", wb_data, TBL[k][31:0]);
      @(negedge clk);
    end
    #1 chk("R5 drained", wb_en, 0);

    // Fill with wrap, extra issue ignored
    for (int i = 0; i < 8; i++) begin
      do_issue(5'(i + 8), 32'h200 + i*4, 0, tg);
      chk("R2 wrap tag", tg, (6 + i) % 8);
    end
    #1 chk("R3 stall full", iss_stall, 1);
    do_issue(5'd31, 32'h300, 0, tg);
    commits = 0; saw31 = 0;
    for (int i = 0; i < 8; i++) begin
      do_cpl(3'((6 + i) % 8), 32'h500 + i, 0);
      #1 if (wb_en) begin commits++; if (wb_reg == 5'd31) saw31 = 1; end
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1 if (wb_en) begin commits++; if (wb_reg == 5'd31) saw31 = 1; end
    end
    chk("R3 commits", commits, 8);
    chk("R3 rejected issue", saw31, 0);

    // R9 newest only
    do_issue(5'd3, 32'h400, 0, tg);
    do_issue(5'd3, 32'h404, 0, tg);
    do_cpl(tg - 3'd1, 32'h111, 0);
    opa_reg = 5'd3; #1;
    chk("R9 old done, newest pending", opa_ready, 0);
    do_cpl(tg, 32'h222, 0);
    #1;
    chk("R9 newest ready", opa_ready, 1);
    chk("R9 newest value", opa_val, 32'h222);
    repeat (3) @(negedge clk);

    // R10 store
    do_issue(5'd12, 32'h500, 1, tg);
    opa_reg = 5'd12; #1;
    chk("R10 store no hit", opa_hit, 0);
    do_cpl(tg, 32'h0, 0);
    #1;
    chk("R10 release", st_release, 1);
    chk("R10 no write", wb_en, 0);
    @(negedge clk); #1;
    chk("R10 one pulse", st_release, 0);

    // R6 trap behind finished younger slot
    do_issue(5'd4, 32'h600, 0, tg);
    do_issue(5'd5, 32'h604, 0, tg);
    do_cpl(tg, 32'h55, 0);
    do_cpl(tg - 3'd1, 32'h44, 4'd2);
    #1;
    chk("R6 trap", trap_valid, 1);
    chk("R6 pc", trap_pc, 32'h600);
    chk("R6 code", trap_code, 2);
    chk("R6 stall", iss_stall, 1);
    commits = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1 if (wb_en) commits++;
    end
    chk("R6 no writes", commits, 0);
    chk("R6 held", trap_valid, 1);

    // R11 flush
    flush = 1; @(negedge clk); flush = 0;
    opa_reg = 5'd5; #1;
    chk("R11 trap clear", trap_valid, 0);
    chk("R11 stall clear", iss_stall, 0);
    chk("R11 lookup miss", opa_hit, 0);
    do_issue(5'd7, 32'h700, 0, tg);
    chk("R11 tag zero", tg, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule